// File: doc/BRIEF.md
# Memory Access Alignment Guard

This block stands between a processor's load/store and fetch paths and the memory port. It takes one request at a time: the access kind, the byte length, the address, and a flag that tells it whether compressed instructions are enabled. A request that breaks the alignment rule is stopped at the guard and never reaches memory. A correctly aligned request goes on to memory with a valid/ready handshake, and the guard then waits for the response.

There are two ways an exception can arise, and both are reported to the trap unit as a single-cycle strobe with an exception code and a fault value. The first is a misaligned access, which the guard detects itself. The second is an error flagged in a memory response. In both cases the fault value is the address of the access. Because a misaligned access is never issued, it cannot also collect a memory error, so the alignment fault is the only one reported for it.

Top module: `memAlignGuard`

## Requirements
- R1: The access kind is encoded as 0 = fetch, 1 = load, 2 = store. Code 3 is handled like a load. When `compressedEn` is 1, a fetch is misaligned exactly when address bit 0 is set.
- R2: When `compressedEn` is 0, a fetch is misaligned whenever address bits [1:0] are non-zero, whatever its length.
- R3: A load or store of length 2 or 4 is misaligned when address AND (length−1) is non-zero. A length of 1 is never misaligned.
- R4: A misaligned fetch or load reports code 4, and a misaligned store reports code 6. `trapValue` equals the request address. The report is visible in the cycle after the request is accepted.
- R5: A misaligned access is never forwarded: `memValid` stays low.
- R6: An aligned access raises `memValid` in the cycle after acceptance, carrying the request's address, kind and length. These stay stable until the cycle in which `memReady` is high.
- R7: A response with `rspErr` = 1 reports code 7 for a store and code 5 for a fetch or load. `trapValue` is the access address. The report appears in the cycle after `rspValid`.
- R8: `rspErr` is ignored while `rspValid` is low, and an error-free response raises no trap.
- R9: `trapValid` lasts exactly one cycle. `reqReady` is low while an access is outstanding and during the cycle in which a trap is being reported.
- R10: Out of reset, `reqReady` is 1 and both `memValid` and `trapValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Guard can accept a request |
| reqKind | input | 2 | 0 fetch, 1 load, 2 store |
| reqLen | input | 3 | Byte length 1, 2 or 4 |
| reqAddr | input | 32 | Byte address |
| compressedEn | input | 1 | Compressed instructions enabled (2-byte fetch alignment) |
| memValid | output | 1 | Request to memory valid |
| memReady | input | 1 | Memory takes the request |
| memKind | output | 2 | Kind of the forwarded access |
| memLen | output | 3 | Length of the forwarded access |
| memAddr | output | 32 | Address of the forwarded access |
| rspValid | input | 1 | Memory response present |
| rspErr | input | 1 | Response carries an error |
| trapValid | output | 1 | One-cycle exception strobe |
| trapCause | output | 4 | Exception code (4, 5, 6 or 7) |
| trapValue | output | 32 | Faulting address |

## Verification
Suppose the captured address, kind or length were wrong, or were captured at the wrong time. The memory port would show it in the cycle after acceptance, and a later error response would also report the wrong fault value and code. A control state that gets stuck shows up in a different way: either `reqReady` stays low, or `memValid` or `trapValid` stays high past its single cycle. A wrong alignment decision shows up within one cycle in a different way again: either the trap strobe appears when it should not, or a misaligned request shows up on the memory port. The bench therefore sweeps every kind, length, low address pair and compressed setting, and checks each outcome in the exact cycle it should appear.

// File: rtl/memGuardPkg.sv
package memGuardPkg;
  localparam int CAUSE_W = 4;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [CAUSE_W-1:0] CODE_RD_MISALIGN = 4'd4;
  localparam logic [CAUSE_W-1:0] CODE_RD_FAULT    = 4'd5;
  localparam logic [CAUSE_W-1:0] CODE_WR_MISALIGN = 4'd6;
  localparam logic [CAUSE_W-1:0] CODE_WR_FAULT    = 4'd7;

  typedef struct packed {
    logic captureReq;
    logic raiseMisalign;
    logic raiseBusErr;
  } guardCtrlS;
endpackage

// File: rtl/alignCheck.sv
module alignCheck
  import memGuardPkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic [1:0]       kind,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       addrLow,
  input  logic             compressedEn,
  output logic             misaligned
);
  localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(4);

  always_comb begin
    if (kind == KIND_FETCH) begin
      // instruction fetch: alignment set by compressed support
      misaligned = compressedEn ? addrLow[0] : (addrLow != 2'b00);
    end else if (len == LEN_HALF) begin
      misaligned = addrLow[0];
    end else if (len == LEN_WORD) begin
      misaligned = (addrLow != 2'b00);
    end else begin
      misaligned = 1'b0;
    end
  end
endmodule

// File: rtl/guardCtrl.sv
module guardCtrl
  import memGuardPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      misaligned,
  input  logic      memReady,
  input  logic      rspValid,
  input  logic      rspErr,
  output logic      reqReady,
  output logic      memValid,
  output guardCtrlS ctrl
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} stateE;

  stateE stateQ, stateD;
  logic  trapBusyQ;
  logic  accept;

  assign reqReady = (stateQ == ST_IDLE) && !trapBusyQ;
  assign memValid = (stateQ == ST_ISSUE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    ctrl               = '0;
    ctrl.captureReq    = accept && !misaligned;
    ctrl.raiseMisalign = accept && misaligned;
    ctrl.raiseBusErr   = (stateQ == ST_WAIT) && rspValid && rspErr;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (accept && !misaligned) stateD = ST_ISSUE;
      ST_ISSUE: if (memReady) stateD = ST_WAIT;
      ST_WAIT:  if (rspValid) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      trapBusyQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      trapBusyQ <= ctrl.raiseMisalign || ctrl.raiseBusErr;
    end
  end
endmodule

// File: rtl/guardDatapath.sv
module guardDatapath
  import memGuardPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  guardCtrlS          ctrl,
  input  logic [1:0]         reqKind,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [1:0]         memKind,
  output logic [LEN_W-1:0]   memLen,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               trapValid,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [ADDR_W-1:0]  trapValue
);
  logic [1:0]         kindQ;
  logic [LEN_W-1:0]   lenQ;
  logic [ADDR_W-1:0]  addrQ;
  logic               trapValidQ;
  logic [CAUSE_W-1:0] causeQ;
  logic [ADDR_W-1:0]  valueQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_FETCH;
      lenQ  <= '0;
      addrQ <= '0;
    end else if (ctrl.captureReq) begin
      kindQ <= reqKind;
      lenQ  <= reqLen;
      addrQ <= reqAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapValidQ <= 1'b0;
      causeQ     <= '0;
      valueQ     <= '0;
    end else begin
      trapValidQ <= ctrl.raiseMisalign || ctrl.raiseBusErr;
      if (ctrl.raiseMisalign) begin
        causeQ <= (reqKind == KIND_STORE) ? CODE_WR_MISALIGN : CODE_RD_MISALIGN;
        valueQ <= reqAddr;
      end else if (ctrl.raiseBusErr) begin
        causeQ <= (kindQ == KIND_STORE) ? CODE_WR_FAULT : CODE_RD_FAULT;
        valueQ <= addrQ;
      end
    end
  end

  assign memKind   = kindQ;
  assign memLen    = lenQ;
  assign memAddr   = addrQ;
  assign trapValid = trapValidQ;
  assign trapCause = causeQ;
  assign trapValue = valueQ;
endmodule

// File: rtl/memAlignGuard.sv
module memAlignGuard
  import memGuardPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqKind,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               compressedEn,
  output logic               memValid,
  input  logic               memReady,
  output logic [1:0]         memKind,
  output logic [LEN_W-1:0]   memLen,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               rspValid,
  input  logic               rspErr,
  output logic               trapValid,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [ADDR_W-1:0]  trapValue
);
  guardCtrlS ctrl;
  logic      misaligned;

  alignCheck #(.LEN_W(LEN_W)) u_align (
    .kind(reqKind), .len(reqLen), .addrLow(reqAddr[1:0]),
    .compressedEn(compressedEn), .misaligned(misaligned)
  );

  guardCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .misaligned(misaligned),
    .memReady(memReady), .rspValid(rspValid), .rspErr(rspErr),
    .reqReady(reqReady), .memValid(memValid), .ctrl(ctrl)
  );

  guardDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqKind(reqKind), .reqLen(reqLen),
    .reqAddr(reqAddr), .memKind(memKind), .memLen(memLen), .memAddr(memAddr),
    .trapValid(trapValid), .trapCause(trapCause), .trapValue(trapValue)
  );
endmodule

// File: rtl/memAlignGuardChecker.sv
module memAlignGuardChecker
  import memGuardPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [1:0]         reqKind,
  input logic [LEN_W-1:0]   reqLen,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               compressedEn,
  input logic               memValid,
  input logic               memReady,
  input logic [1:0]         memKind,
  input logic [LEN_W-1:0]   memLen,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               rspValid,
  input logic               rspErr,
  input logic               trapValid,
  input logic [CAUSE_W-1:0] trapCause,
  input logic [ADDR_W-1:0]  trapValue
);
  logic badAlign;
  assign badAlign = (reqKind == KIND_FETCH)
                    ? (compressedEn ? reqAddr[0] : (reqAddr[1:0] != 2'b00))
                    : ((reqLen == LEN_W'(2)) ? reqAddr[0]
                       : (reqLen == LEN_W'(4)) ? (reqAddr[1:0] != 2'b00) : 1'b0);

  assert_misalign_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badAlign) |=> (trapValid && !memValid && trapValue == $past(reqAddr)));

  assert_misalign_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badAlign) |=>
      (trapCause == (($past(reqKind) == KIND_STORE) ? CODE_WR_MISALIGN : CODE_RD_MISALIGN)));

  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memKind) && $stable(memLen)));

  assert_store_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memKind == KIND_STORE) |->
      ((memLen == LEN_W'(4)) ? (memAddr[1:0] == 2'b00) : (memLen == LEN_W'(2)) ? !memAddr[0] : 1'b1));

  assert_fault_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && (trapCause == CODE_RD_FAULT || trapCause == CODE_WR_FAULT)) |->
      $past(rspValid && rspErr));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);

  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || trapValid) |-> !reqReady);
endmodule

bind memAlignGuard memAlignGuardChecker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/memAlignGuard_bench.sv
module memAlignGuard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic [2:0]  reqLen = 3'd1;
  logic [31:0] reqAddr = '0;
  logic        compressedEn = 1'b0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [1:0]  memKind;
  logic [2:0]  memLen;
  logic [31:0] memAddr;
  logic        rspValid = 1'b0;
  logic        rspErr = 1'b0;
  logic        trapValid;
  logic [3:0]  trapCause;
  logic [31:0] trapValue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  memAlignGuard u_memAlignGuard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqLen(reqLen), .reqAddr(reqAddr),
    .compressedEn(compressedEn), .memValid(memValid), .memReady(memReady),
    .memKind(memKind), .memLen(memLen), .memAddr(memAddr),
    .rspValid(rspValid), .rspErr(rspErr), .trapValid(trapValid),
    .trapCause(trapCause), .trapValue(trapValue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runAccess(input logic [1:0] kind, input logic [2:0] len,
                           input logic [31:0] addr, input bit cmp, input bit err);
    int  align;
    bit  mis;
    align = (kind == 2'd0) ? (cmp ? 2 : 4) : int'(len);
    mis   = (align > 1) && ((addr % align) != 0);
    @(negedge clk);
    check("R9 reqReady idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqKind = kind; reqLen = len; reqAddr = addr; compressedEn = cmp;
    memReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (mis) begin
      // R1 R2 R3 R4: misaligned report in cycle after acceptance
      check("R4 trapValid", 32'(trapValid), 32'd1);
      check("R4 trapCause", 32'(trapCause), (kind == 2'd2) ? 32'd6 : 32'd4);
      check("R4 trapValue", trapValue, addr);
      check("R5 memValid low", 32'(memValid), 32'd0);
      check("R9 reqReady low on trap", 32'(reqReady), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check("R9 strobe ends", 32'(trapValid), 32'd0);
      check("R5 memValid still low", 32'(memValid), 32'd0);
    end else begin
      check("R1 R2 R3 no trap on aligned", 32'(trapValid), 32'd0);
      check("R6 memValid", 32'(memValid), 32'd1);
      check("R6 memAddr", memAddr, addr);
      check("R6 memKind", 32'(memKind), 32'(kind));
      check("R6 memLen", 32'(memLen), 32'(len));
      check("R9 busy", 32'(reqReady), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check("R6 held while stalled", memAddr, addr);
      check("R6 valid held", 32'(memValid), 32'd1);
      memReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      memReady = 1'b0;
      check("R6 valid drops after ready", 32'(memValid), 32'd0);
      rspErr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R8 rspErr ignored without rspValid", 32'(trapValid), 32'd0);
      rspValid = 1'b1; rspErr = err;
      @(posedge clk);
      @(negedge clk);
      rspValid = 1'b0; rspErr = 1'b0;
      if (err) begin
        check("R7 trapValid", 32'(trapValid), 32'd1);
        check("R7 trapCause", 32'(trapCause), (kind == 2'd2) ? 32'd7 : 32'd5);
        check("R7 trapValue", trapValue, addr);
      end else begin
        check("R8 clean response no trap", 32'(trapValid), 32'd0);
      end
      @(posedge clk);
      @(negedge clk);
      check("R9 strobe ends", 32'(trapValid), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reqReady", 32'(reqReady), 32'd1);
    check("R10 memValid", 32'(memValid), 32'd0);
    check("R10 trapValid", 32'(trapValid), 32'd0);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      for (int l = 0; l < 3; l++) begin
        for (int lo = 0; lo < 4; lo++) begin
          for (int c = 0; c < 2; c++) begin
            for (int e = 0; e < 2; e++) begin
              logic [2:0]  len;
              logic [31:0] addr;
              len  = (l == 0) ? 3'd1 : (l == 1) ? 3'd2 : 3'd4;
              addr = 32'hA5C3_0000 + 32'(((k * 3 + l) * 2 + c) * 32'h0104) + 32'(e * 16);
              addr = {addr[31:2], 2'(lo)};
              runAccess(2'(k), len, addr, c[0], e[0]);
            end
          end
        end
      end
    end
    // R1: kind code 3 behaves like a load
    runAccess(2'd3, 3'd4, 32'h0000_1002, 1'b1, 1'b0);
    runAccess(2'd3, 3'd2, 32'h0000_2004, 1'b0, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule